// File: doc/BRIEF.md
# SPI Register Front End with Counter Burst Readout

This block is the host-facing side of a bank of up to three position counters. An external SPI master (mode 0: data sampled on the rising SCLK edge and changed on the falling edge, most significant bit first) opens a transaction by pulling chip select low. The first byte it sends is an address byte. Its top bit selects read (1) or write (0), and its low seven bits give the register address. Each byte after that is either write data or read data, and the address steps forward by one on every byte. Three register addresses exist. The configuration byte at 0x00 can be read and written. The command byte at 0x30 can only be written, and each write produces a one-cycle strobe toward the counter bank. The per-channel status bytes sit at 0x48, 0x49 and 0x4A and can only be read.

When a read transaction opens at address 0x08, the block streams a burst built from the live counter values. The counter values are captured into a snapshot at the moment the address byte is decoded. The active counters follow the 3-bit code held in the low bits of the configuration register. They are sent big-endian with the highest-numbered counter first, and one last byte follows that carries the active-low error and warning inputs. The block connects to the counter bank through parallel buses: counter values, status bytes, a command strobe and per-channel read-clear strobes. The SPI pins pass through two-flop synchronizers into the system clock domain.

Top module: `spireg_front`

## Requirements
- R1: The address byte is received MSB first on rising SCLK edges. Bit 7 = 1 selects a read and bit 7 = 0 selects a write. Bits 6:0 are the address. During a read, each returned data byte is presented MSB first, and its first bit is valid before the first rising edge of that byte.
- R2: Address 0x00 is a configuration register that is both written and read back over SPI. It resets to 0x00 and is driven continuously on `cfg_out`. Bits 2:0 form the counter layout code.
- R3: A completed write to address 0x30 produces exactly one `cmd_strobe` pulse of one cycle, with the written byte on `cmd_data`. Reading address 0x30 returns 0x00.
- R4: A read of address 0x48+k returns `stat_in[8k+7:8k]` for channel k (k = 0, 1, 2). Writes to these addresses change nothing. Any other address that is not 0x00 reads as 0x00.
- R5: After each data byte the address advances by one, for both reads and writes.
- R6: A read opened at 0x08 sends the active counters big-endian, highest-numbered counter first. The layout codes are: 0 = c0[23:0]; 1 = c1[23:0], c0[23:0]; 2 = c0[47:0]; 3 = c0[15:0]; 4 = c0[31:0]; 5 = c1[31:0], c0[15:0]; 6 = c1[15:0], c0[15:0]; 7 = c2[15:0], c1[15:0], c0[15:0]. Counter k occupies `cnt_in[48k+47:48k]`.
- R7: The burst is 4, 7, 7, 3, 5, 7, 5 and 7 bytes long for codes 0 to 7. Its last byte is {nerr_n, nwarn_n, 6'b0}. Every later byte of the same transaction reads 0x00.
- R8: The burst is taken from a snapshot captured when the address byte is decoded. A change on `cnt_in` during the burst does not appear in it.
- R9: Once all 8 bits of a status byte for channel k have been clocked out, `rd_clr[k]` pulses for one cycle. A status read abandoned before its 8th bit produces no pulse.
- R10: `spi_miso_oe` is low whenever chip select is inactive and high while it is active.
- R11: If chip select rises in the middle of a byte, the partial byte is discarded and no register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock (asynchronous) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from master |
| spi_miso | output | 1 | SPI data to master |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| cnt_in | input | NCH*CNT_W | Live counter values, counter k at slot k |
| nerr_n | input | 1 | Active-low error indication |
| nwarn_n | input | 1 | Active-low warning indication |
| stat_in | input | NCH*8 | Status byte of each channel |
| cfg_out | output | 8 | Configuration register contents |
| cmd_strobe | output | 1 | One-cycle pulse on a command write |
| cmd_data | output | 8 | Command byte written |
| rd_clr | output | NCH | Per-channel read-clear pulse for sticky status flags |

## Verification
Errors in the bit counter or in the tracking of the first byte show up within one byte. Either the address lands in the wrong register, or the returned data comes back shifted by a bit, and the next readback catches it. If the burst index or the layout decode is wrong, some byte of the 8-byte readout is misplaced. Running all eight layout codes, each with distinct counter bytes, exposes such an error on its first bad byte. A snapshot that follows the live input instead of holding still appears only when the counters change in the middle of a burst, so the bench does exactly that. Read-clear and command strobes are counted at the ports, so a missing or doubled pulse shows up right after the transaction that should have produced it.

// File: rtl/spireg_pkg.sv
package spireg_pkg;

  localparam int FRAME_W = 64;

  localparam logic [6:0] A_CFG   = 7'h00;
  localparam logic [6:0] A_BURST = 7'h08;
  localparam logic [6:0] A_CMD   = 7'h30;
  localparam logic [6:0] A_STAT0 = 7'h48;

  typedef enum logic [2:0] {
    LAY_24     = 3'd0,
    LAY_24_24  = 3'd1,
    LAY_48     = 3'd2,
    LAY_16     = 3'd3,
    LAY_32     = 3'd4,
    LAY_32_16  = 3'd5,
    LAY_16_16  = 3'd6,
    LAY_16_X3  = 3'd7
  } layout_e;

  // Left-aligned burst image; unused tail bytes stay zero.
  function automatic logic [FRAME_W-1:0] build_frame(
    input layout_e     lay,
    input logic [47:0] c0,
    input logic [47:0] c1,
    input logic [47:0] c2,
    input logic        err_n,
    input logic        warn_n
  );
    logic [7:0]         tail;
    logic [FRAME_W-1:0] f;
    tail = {err_n, warn_n, 6'b0};
    case (lay)
      LAY_24:    f = {c0[23:0], tail, 32'h0};
      LAY_24_24: f = {c1[23:0], c0[23:0], tail, 8'h0};
      LAY_48:    f = {c0[47:0], tail, 8'h0};
      LAY_16:    f = {c0[15:0], tail, 40'h0};
      LAY_32:    f = {c0[31:0], tail, 24'h0};
      LAY_32_16: f = {c1[31:0], c0[15:0], tail, 8'h0};
      LAY_16_16: f = {c1[15:0], c0[15:0], tail, 24'h0};
      default:   f = {c2[15:0], c1[15:0], c0[15:0], tail, 8'h0};
    endcase
    return f;
  endfunction

endpackage

// File: rtl/spireg_sync.sv
module spireg_sync #(
  parameter int         W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1_q[i] <= RST_VAL[i];
        stage2_q[i] <= RST_VAL[i];
      end else begin
        stage1_q[i] <= async_in[i];
        stage2_q[i] <= stage1_q[i];
      end
    end
  end

  assign sync_out = stage2_q;

endmodule

// File: rtl/spireg_shift.sv
module spireg_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_act,
  input  logic       sclk_s,
  input  logic       mosi_s,
  input  logic       tx_load,
  input  logic [7:0] tx_byte,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       first_byte,
  output logic       miso,
  output logic       miso_oe
);

  logic       sclk_prev_q;
  logic       sclk_rise, sclk_fall;
  logic [2:0] bit_q, bit_d;
  logic [6:0] rx_q, rx_d;
  logic [7:0] tx_q, tx_d;
  logic       first_q, first_d;
  logic       oe_q;

  assign sclk_rise  = sclk_s & ~sclk_prev_q;
  assign sclk_fall  = ~sclk_s & sclk_prev_q;
  assign byte_done  = cs_act & sclk_rise & (bit_q == 3'd7);
  assign rx_byte    = {rx_q, mosi_s};
  assign first_byte = first_q;
  assign miso       = tx_q[7];
  assign miso_oe    = oe_q;

  always_comb begin
    bit_d   = bit_q;
    rx_d    = rx_q;
    tx_d    = tx_q;
    first_d = first_q;
    if (!cs_act) begin
      bit_d   = '0;
      rx_d    = '0;
      tx_d    = '0;
      first_d = 1'b1;
    end else begin
      if (sclk_rise) begin
        bit_d = bit_q + 3'd1;
        rx_d  = {rx_q[5:0], mosi_s};
        if (byte_done) first_d = 1'b0;
      end
      // Hold the first bit of a fresh byte across the boundary falling edge.
      if (sclk_fall && (bit_q != 3'd0)) tx_d = {tx_q[6:0], 1'b0};
      if (tx_load) tx_d = tx_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      bit_q       <= '0;
      rx_q        <= '0;
      tx_q        <= '0;
      first_q     <= 1'b1;
      oe_q        <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_s;
      bit_q       <= bit_d;
      rx_q        <= rx_d;
      tx_q        <= tx_d;
      first_q     <= first_d;
      oe_q        <= cs_act;
    end
  end

  assert_bits_flushed_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (bit_q == 3'd0 && first_q));

  assert_oe_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !miso_oe);

endmodule

// File: rtl/spireg_core.sv
module spireg_core
  import spireg_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int CNT_W = 48
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_act,
  input  logic                 byte_done,
  input  logic                 first_byte,
  input  logic [7:0]           rx_byte,
  input  logic [NCH*CNT_W-1:0] cnt_in,
  input  logic [NCH*8-1:0]     stat_in,
  input  logic                 nerr_n,
  input  logic                 nwarn_n,
  output logic                 tx_load,
  output logic [7:0]           tx_byte,
  output logic [7:0]           cfg_out,
  output logic                 cmd_strobe,
  output logic [7:0]           cmd_data,
  output logic [NCH-1:0]       rd_clr
);

  localparam int SLOTS = 3;
  localparam int IDX_W = 4;
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(FRAME_W / 8);

  logic [47:0] slot [SLOTS];
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    if (k < NCH) begin : g_used
      if (CNT_W >= 48) begin : g_trim
        assign slot[k] = cnt_in[k*CNT_W +: 48];
      end else begin : g_pad
        assign slot[k] = {{(48-CNT_W){1'b0}}, cnt_in[k*CNT_W +: CNT_W]};
      end
    end else begin : g_none
      assign slot[k] = '0;
    end
  end

  logic [6:0]         addr_q, addr_d, addr_inc;
  logic               rd_q, rd_d;
  logic               burst_q, burst_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [FRAME_W-1:0] snap_q, snap_d, live_frame;
  logic [7:0]         cfg_q, cfg_d;
  logic               cmd_q, cmd_d;
  logic [7:0]         cmdv_q, cmdv_d;
  logic [NCH-1:0]     pend_q, pend_d;
  logic [7:0]         burst_byte;

  function automatic logic [7:0] reg_read(input logic [6:0] a, input logic [7:0] cfg,
                                           input logic [NCH*8-1:0] st);
    logic [7:0] r;
    r = 8'h00;
    if (a == A_CFG) r = cfg;
    for (int k = 0; k < NCH; k++)
      if (a == A_STAT0 + 7'(k)) r = st[k*8 +: 8];
    return r;
  endfunction

  function automatic logic [NCH-1:0] stat_sel(input logic [6:0] a);
    logic [NCH-1:0] s;
    s = '0;
    for (int k = 0; k < NCH; k++)
      if (a == A_STAT0 + 7'(k)) s[k] = 1'b1;
    return s;
  endfunction

  assign live_frame = build_frame(layout_e'(cfg_q[2:0]), slot[0], slot[1], slot[2],
                                  nerr_n, nwarn_n);
  assign addr_inc   = addr_q + 7'd1;
  assign burst_byte = idx_q[IDX_W-1] ? 8'h00
                                     : snap_q[{3'd7 - idx_q[2:0], 3'b000} +: 8];

  always_comb begin
    addr_d  = addr_q;
    rd_d    = rd_q;
    burst_d = burst_q;
    idx_d   = idx_q;
    snap_d  = snap_q;
    cfg_d   = cfg_q;
    cmd_d   = 1'b0;
    cmdv_d  = cmdv_q;
    pend_d  = pend_q;
    tx_load = 1'b0;
    tx_byte = 8'h00;
    rd_clr  = '0;
    if (!cs_act) begin
      rd_d    = 1'b0;
      burst_d = 1'b0;
      idx_d   = '0;
      pend_d  = '0;
    end else if (byte_done) begin
      if (first_byte) begin
        addr_d  = rx_byte[6:0];
        rd_d    = rx_byte[7];
        burst_d = rx_byte[7] && (rx_byte[6:0] == A_BURST);
        if (rx_byte[7]) begin
          tx_load = 1'b1;
          if (rx_byte[6:0] == A_BURST) begin
            snap_d  = live_frame;
            tx_byte = live_frame[FRAME_W-1 -: 8];
            idx_d   = IDX_W'(1);
          end else begin
            tx_byte = reg_read(rx_byte[6:0], cfg_q, stat_in);
            pend_d  = stat_sel(rx_byte[6:0]);
          end
        end
      end else begin
        addr_d = addr_inc;
        rd_clr = pend_q;
        pend_d = '0;
        if (rd_q) begin
          tx_load = 1'b1;
          if (burst_q) begin
            tx_byte = burst_byte;
            if (idx_q != IDX_END) idx_d = idx_q + IDX_W'(1);
          end else begin
            tx_byte = reg_read(addr_inc, cfg_q, stat_in);
            pend_d  = stat_sel(addr_inc);
          end
        end else begin
          if (addr_q == A_CFG) cfg_d = rx_byte;
          if (addr_q == A_CMD) begin
            cmd_d  = 1'b1;
            cmdv_d = rx_byte;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      rd_q    <= 1'b0;
      burst_q <= 1'b0;
      idx_q   <= '0;
      snap_q  <= '0;
      cfg_q   <= '0;
      cmd_q   <= 1'b0;
      cmdv_q  <= '0;
      pend_q  <= '0;
    end else begin
      addr_q  <= addr_d;
      rd_q    <= rd_d;
      burst_q <= burst_d;
      idx_q   <= idx_d;
      snap_q  <= snap_d;
      cfg_q   <= cfg_d;
      cmd_q   <= cmd_d;
      cmdv_q  <= cmdv_d;
      pend_q  <= pend_d;
    end
  end

  assign cfg_out    = cfg_q;
  assign cmd_strobe = cmd_q;
  assign cmd_data   = cmdv_q;

  assert_cmd_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |=> !cmd_strobe);

  assert_clr_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_clr));

  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_done && !first_byte && !rd_q) |=> $stable(cfg_out));

  assert_snap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && burst_q) |=> $stable(snap_q));

endmodule

// File: rtl/spireg_front.sv
module spireg_front
  import spireg_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int CNT_W = 48
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 spi_sclk,
  input  logic                 spi_cs_n,
  input  logic                 spi_mosi,
  output logic                 spi_miso,
  output logic                 spi_miso_oe,
  input  logic [NCH*CNT_W-1:0] cnt_in,
  input  logic                 nerr_n,
  input  logic                 nwarn_n,
  input  logic [NCH*8-1:0]     stat_in,
  output logic [7:0]           cfg_out,
  output logic                 cmd_strobe,
  output logic [7:0]           cmd_data,
  output logic [NCH-1:0]       rd_clr
);

  logic [1:0] rst_pipe_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  logic [2:0] pins_s;
  logic       cs_act, byte_done, first_byte, tx_load;
  logic [7:0] rx_byte, tx_byte;

  spireg_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .async_in ({spi_cs_n, spi_sclk, spi_mosi}),
    .sync_out (pins_s)
  );

  assign cs_act = ~pins_s[2];

  spireg_shift u_shift (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .cs_act     (cs_act),
    .sclk_s     (pins_s[1]),
    .mosi_s     (pins_s[0]),
    .tx_load    (tx_load),
    .tx_byte    (tx_byte),
    .byte_done  (byte_done),
    .rx_byte    (rx_byte),
    .first_byte (first_byte),
    .miso       (spi_miso),
    .miso_oe    (spi_miso_oe)
  );

  spireg_core #(.NCH(NCH), .CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .cs_act     (cs_act),
    .byte_done  (byte_done),
    .first_byte (first_byte),
    .rx_byte    (rx_byte),
    .cnt_in     (cnt_in),
    .stat_in    (stat_in),
    .nerr_n     (nerr_n),
    .nwarn_n    (nwarn_n),
    .tx_load    (tx_load),
    .tx_byte    (tx_byte),
    .cfg_out    (cfg_out),
    .cmd_strobe (cmd_strobe),
    .cmd_data   (cmd_data),
    .rd_clr     (rd_clr)
  );

endmodule

// File: tb/spireg_front_bench.sv
module spireg_front_bench;

  localparam int NCH  = 3;
  localparam int CW   = 48;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe;
  logic [NCH*CW-1:0] cnt_in;
  logic nerr_n, nwarn_n;
  logic [NCH*8-1:0] stat_in;
  logic [7:0] cfg_out, cmd_data;
  logic cmd_strobe;
  logic [NCH-1:0] rd_clr;

  always #2.5 clk = ~clk;

  spireg_front #(.NCH(NCH), .CNT_W(CW)) u_spireg_front (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .cnt_in(cnt_in), .nerr_n(nerr_n), .nwarn_n(nwarn_n), .stat_in(stat_in),
    .cfg_out(cfg_out), .cmd_strobe(cmd_strobe), .cmd_data(cmd_data), .rd_clr(rd_clr)
  );

  // {layout code, expected 8-byte readout}
  localparam logic [66:0] VEC [8] = '{
    {3'd0, 64'hA4A5A680_00000000},
    {3'd1, 64'hB4B5B6A4_A5A68000},
    {3'd2, 64'hA1A2A3A4_A5A68000},
    {3'd3, 64'hA5A68000_00000000},
    {3'd4, 64'hA3A4A5A6_80000000},
    {3'd5, 64'hB3B4B5B6_A5A68000},
    {3'd6, 64'hB5B6A5A6_80000000},
    {3'd7, 64'hC5C6B5B6_A5A68000}
  };

  int compared = 0, mismatched = 0;
  int cmd_cnt = 0;
  logic [7:0] cmd_last = 8'h00;
  int clr_cnt [NCH];
  bit done = 0;

  initial for (int k = 0; k < NCH; k++) clr_cnt[k] = 0;

  always @(negedge clk) if (rst_n) begin
    if (cmd_strobe) begin cmd_cnt++; cmd_last = cmd_data; end
    for (int k = 0; k < NCH; k++) if (rd_clr[k]) clr_cnt[k]++;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = 8'h00;
    for (int b = 7; b > 7 - n; b--) begin
      spi_mosi = tx[b];
      repeat (HALF) @(negedge clk);
      rx[b] = spi_miso;
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    xfer_bits(tx, 8, rx);
  endtask

  task automatic cs_lo;
    @(negedge clk) spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_hi;
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] r;
    cs_lo; xfer({1'b0, a}, r); xfer(d, r); cs_hi;
  endtask

  task automatic rd_reg(input logic [6:0] a, output logic [7:0] d);
    logic [7:0] r;
    cs_lo; xfer({1'b1, a}, r); xfer(8'h00, d); cs_hi;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int c0;
    cnt_in  = {48'hC1C2C3C4C5C6, 48'hB1B2B3B4B5B6, 48'hA1A2A3A4A5A6};
    nerr_n  = 1'b1;
    nwarn_n = 1'b0;
    stat_in = {8'h33, 8'h22, 8'h11};
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // Reset state
    chk("R2 reset cfg", 64'(cfg_out), 64'h00);
    chk("R10 idle oe", 64'(spi_miso_oe), 64'h0);
    chk("R3 no strobe at reset", 64'(cmd_cnt), 64'd0);

    // Vector walk: every layout code
    for (int i = 0; i < 8; i++) begin
      wr_reg(7'h00, {5'b10100, VEC[i][66:64]});
      chk("R2 cfg port", 64'(cfg_out), 64'({5'b10100, VEC[i][66:64]}));
      rd_reg(7'h00, d);
      chk("R1 R2 cfg readback", 64'(d), 64'({5'b10100, VEC[i][66:64]}));
      cs_lo;
      chk("R10 oe active", 64'(spi_miso_oe), 64'h1);
      xfer(8'h88, d);
      for (int j = 0; j < 8; j++) begin
        xfer(8'h00, d);
        chk("R6 R7 burst byte", 64'(d), 64'(VEC[i][63-8*j -: 8]));
      end
      cs_hi;
      chk("R10 oe idle after", 64'(spi_miso_oe), 64'h0);
    end

    // R7: status tail follows the flag inputs
    nerr_n = 1'b0; nwarn_n = 1'b1;
    wr_reg(7'h00, 8'h03);
    cs_lo; xfer(8'h88, d);
    xfer(8'h00, d); chk("R6 16-bit hi", 64'(d), 64'hA5);
    xfer(8'h00, d); chk("R6 16-bit lo", 64'(d), 64'hA6);
    xfer(8'h00, d); chk("R7 tail flags", 64'(d), 64'h40);
    xfer(8'h00, d); chk("R7 past end", 64'(d), 64'h00);
    cs_hi;
    nerr_n = 1'b1; nwarn_n = 1'b0;

    // R8: counters change mid-burst
    wr_reg(7'h00, 8'h02);
    cs_lo; xfer(8'h88, d);
    cnt_in[47:0] = 48'h010203040506;
    for (int j = 0; j < 6; j++) begin
      xfer(8'h00, d);
      chk("R8 snapshot", 64'(d), 64'(8'hA1 + 8'(j)));
    end
    xfer(8'h00, d); chk("R8 snapshot tail", 64'(d), 64'h80);
    cs_hi;
    cs_lo; xfer(8'h88, d);
    xfer(8'h00, d); chk("R8 new snapshot", 64'(d), 64'h01);
    cs_hi;

    // R4 R5 R9: status bytes with auto increment and read-clear
    cs_lo; xfer(8'hC8, d);
    xfer(8'h00, d); chk("R4 stat0", 64'(d), 64'h11);
    xfer(8'h00, d); chk("R5 stat1", 64'(d), 64'h22);
    xfer(8'h00, d); chk("R5 stat2", 64'(d), 64'h33);
    xfer(8'h00, d); chk("R4 unmapped", 64'(d), 64'h00);
    cs_hi;
    chk("R9 clr ch0", 64'(clr_cnt[0]), 64'd1);
    chk("R9 clr ch1", 64'(clr_cnt[1]), 64'd1);
    chk("R9 clr ch2", 64'(clr_cnt[2]), 64'd1);

    // R9: abandoned status byte gives no clear
    c0 = clr_cnt[0];
    cs_lo; xfer(8'hC8, d); xfer_bits(8'h00, 5, d); cs_hi;
    chk("R9 abort no clr", 64'(clr_cnt[0]), 64'(c0));

    // R3 R5: command reached by increment from 0x2F
    cs_lo; xfer(8'h2F, d); xfer(8'h55, d); xfer(8'h63, d); cs_hi;
    chk("R3 one strobe", 64'(cmd_cnt), 64'd1);
    chk("R3 cmd data", 64'(cmd_last), 64'h63);
    rd_reg(7'h30, d);
    chk("R3 cmd reads zero", 64'(d), 64'h00);

    // R4: write to status is ignored
    wr_reg(7'h48, 8'hFF);
    rd_reg(7'h48, d);
    chk("R4 stat unchanged", 64'(d), 64'h11);
    chk("R4 cfg untouched", 64'(cfg_out), 64'h02);

    // R5: write increments past cfg without touching it twice
    cs_lo; xfer(8'h00, d); xfer(8'h05, d); xfer(8'hEE, d); cs_hi;
    chk("R5 cfg first byte only", 64'(cfg_out), 64'h05);

    // R11: partial write byte discarded
    cs_lo; xfer(8'h00, d); xfer_bits(8'h07, 5, d); cs_hi;
    chk("R11 partial write", 64'(cfg_out), 64'h05);
    cs_lo; xfer_bits(8'h00, 3, d); cs_hi;
    wr_reg(7'h00, 8'h06);
    chk("R11 recover after abort", 64'(cfg_out), 64'h06);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule